// File: doc/BRIEF.md
# Turn Marker Selector and Orbit Pulse Regenerator

This block runs in the bunch-clock domain. It picks the reference turn marker from one of three places: the marker of the first beam, the marker of the second beam, or a free-running local orbit. It detects the marker's rising edge and holds that trigger back by a programmable number of bunch clocks. It then drives a clean orbit pulse whose length in bunch clocks is also programmable. The local generator repeats every programmed period. The nominal period is 3564 bunch clocks, and a shorter value can be loaded for test.

In manual control the chosen source is used as it is. In automatic control an external source is watched. If the watched marker stays silent for two full expected periods, the block falls back to the local orbit and raises a status flag. The first edge that returns on that marker moves the block back to the external source. That edge also fires a pulse itself.

Each external marker has its own edge counter. A general clear input returns the whole block to its reset state in one cycle.

Top module: `orbit_regen`

## Requirements
- R1: With `src_sel`=0 (beam A) and manual control, each rising edge on `orb_a_in` triggers one output pulse. Edges on `orb_b_in` trigger none.
- R2: With `src_sel`=1 (beam B), each rising edge on `orb_b_in` triggers one output pulse. Edges on `orb_a_in` are ignored.
- R3: With `src_sel`=2 or 3 (local), a trigger fires every `period_cfg` clocks. A `period_cfg` below 2 is treated as 2. After a clear, the first trigger falls on the `period_cfg`-th edge.
- R4: Let E be the clock edge that first samples the selected marker high. `orb_out` goes high at edge E+`delay_cfg`. With zero delay it is high right after E.
- R5: `orb_out` stays high for `width_cfg` clocks. A `width_cfg` of 0 acts as 1.
- R6: A marker held high for several cycles counts as a single rising edge: it gives one pulse and one count.
- R7: `cnt_a` and `cnt_b` each add one for every rising edge on their own marker. This happens whatever source and mode are selected. Both are 32 bits wide and wrap.
- R8: With `auto_en`=1 and an external source selected, `fallback_o` rises at the edge that ends 2×period clocks without a selected edge. From then on, local triggers drive the output.
- R9: While in fallback, a selected external edge clears `fallback_o` at that same edge and fires a pulse. Local triggers stop driving the output after that.
- R10: `gen_clr` high at an edge clears the pulse, the delay, the local phase, the fallback flag and both counters, just as `rst_n` does.
- R11: With `auto_en`=0, `fallback_o` stays low however long the selected marker is silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_clr | input | 1 | Synchronous general clear |
| orb_a_in | input | 1 | Turn marker of beam A |
| orb_b_in | input | 1 | Turn marker of beam B |
| src_sel | input | 2 | 0 beam A, 1 beam B, 2/3 local orbit |
| auto_en | input | 1 | 1 enables automatic fallback |
| delay_cfg | input | 12 | Coarse delay in bunch clocks |
| width_cfg | input | 8 | Output pulse length in bunch clocks |
| period_cfg | input | 12 | Local orbit period in bunch clocks |
| orb_out | output | 1 | Regenerated orbit pulse |
| fallback_o | output | 1 | High while local orbit substitutes the external one |
| cnt_a | output | 32 | Rising edges seen on beam A marker |
| cnt_b | output | 32 | Rising edges seen on beam B marker |

## Verification
The output path is tried with single-cycle markers at zero and non-zero delays, with a width of zero, and with a marker held high over several cycles. These cases separate an off-by-one in the delay or width counters from a level-triggered edge detector. Edges on the unselected beam tell a correct multiplexer apart from one that merges both markers. Cleared-phase local orbits check the period count. An automatic-mode run with one edge, then silence, then a returning edge pins down the exact cycle of entry into fallback and exit from it, and shows that local triggers are suppressed once the external marker is back.

// File: rtl/orbit_pkg.sv
package orbit_pkg;

  typedef enum logic [1:0] {
    SRC_BEAM_A  = 2'd0,
    SRC_BEAM_B  = 2'd1,
    SRC_LOCAL   = 2'd2,
    SRC_LOCAL_X = 2'd3
  } orb_src_e;

  // Raise a configured count to a minimum legal value.
  function automatic int unsigned floor_at(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // Silence window of the automatic watchdog: two expected periods.
  function automatic int unsigned silence_limit(int unsigned period);
    return 2 * floor_at(period, 2);
  endfunction

endpackage

// File: rtl/orb_edge_count.sv
module orb_edge_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             mark_i,
  output logic             rise_o,
  output logic [CNT_W-1:0] count_o
);

  logic             mark_q;
  logic [CNT_W-1:0] count_q;

  assign rise_o  = mark_i & ~mark_q;
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_q  <= 1'b0;
      count_q <= '0;
    end else if (clr_i) begin
      mark_q  <= 1'b0;
      count_q <= '0;
    end else begin
      mark_q <= mark_i;
      if (rise_o) count_q <= count_q + 1'b1;
    end
  end

  // R7: outside a clear the counter only holds or steps by one
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1)));

endmodule

// File: rtl/orb_local_gen.sv
module orb_local_gen #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  import orbit_pkg::*;

  logic [PER_W-1:0] phase_q;
  logic [PER_W-1:0] last_phase;

  assign last_phase = PER_W'(floor_at(32'(period_i), 2) - 1);
  assign tick_o     = (phase_q >= last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

endmodule

// File: rtl/orb_src_sel.sv
module orb_src_sel #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rise_a_i,
  input  logic             rise_b_i,
  input  logic             tick_i,
  input  logic [1:0]       sel_i,
  input  logic             auto_i,
  input  logic [PER_W-1:0] period_i,
  output logic             trig_o,
  output logic             fallback_o
);
  import orbit_pkg::*;

  localparam int GAP_W = PER_W + 1;

  orb_src_e         src;
  logic             use_ext;
  logic             ext_rise;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] limit;
  logic             fb_q;
  logic             silent_out;

  assign src      = orb_src_e'(sel_i);
  assign use_ext  = (src == SRC_BEAM_A) || (src == SRC_BEAM_B);
  assign ext_rise = (src == SRC_BEAM_A) ? rise_a_i :
                    (src == SRC_BEAM_B) ? rise_b_i : 1'b0;
  assign limit      = GAP_W'(silence_limit(32'(period_i)));
  assign silent_out = (gap_q >= limit - 1'b1) && !ext_rise;

  // External edge always wins; local ticks only count when substituting.
  assign trig_o     = use_ext ? (ext_rise | (fb_q & tick_i)) : tick_i;
  assign fallback_o = fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      fb_q  <= 1'b0;
    end else if (clr_i) begin
      gap_q <= '0;
      fb_q  <= 1'b0;
    end else begin
      if (ext_rise)           gap_q <= '0;
      else if (gap_q < limit) gap_q <= gap_q + 1'b1;

      if (!auto_i || !use_ext) fb_q <= 1'b0;
      else if (ext_rise)       fb_q <= 1'b0;
      else if (silent_out)     fb_q <= 1'b1;
    end
  end

  // R8: entry into fallback only in automatic mode on an external source
  a_r8_fallback_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_q) |-> $past(auto_i && use_ext && !ext_rise));

  // R11: manual control never leaves the flag set
  a_r11_manual_no_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_i |=> !fallback_o);

  // R9: a returning external edge ends the fallback
  a_r9_return_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q && ext_rise && !clr_i) |=> !fb_q);

endmodule

// File: rtl/orb_shaper.sv
module orb_shaper #(
  parameter int DLY_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [WID_W-1:0] width_i,
  output logic             pulse_o
);
  import orbit_pkg::*;

  logic             pend_q;
  logic [DLY_W-1:0] dcnt_q;
  logic             pulse_q;
  logic [WID_W-1:0] wleft_q;
  logic             start;
  logic [WID_W-1:0] wload;

  // A new trigger restarts the delay; zero delay fires at once.
  assign start   = trig_i ? (delay_i == '0) : (pend_q && dcnt_q == '0);
  assign wload   = WID_W'(floor_at(32'(width_i), 1) - 1);
  assign pulse_o = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (clr_i) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (trig_i) begin
      pend_q <= (delay_i != '0);
      dcnt_q <= delay_i - 1'b1;
    end else if (pend_q) begin
      if (dcnt_q == '0) pend_q <= 1'b0;
      else              dcnt_q <= dcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      wleft_q <= '0;
    end else if (clr_i) begin
      pulse_q <= 1'b0;
      wleft_q <= '0;
    end else if (start) begin
      pulse_q <= 1'b1;
      wleft_q <= wload;
    end else if (pulse_q) begin
      if (wleft_q == '0) pulse_q <= 1'b0;
      else               wleft_q <= wleft_q - 1'b1;
    end
  end

  // R4: a zero-delay trigger shows on the output after one edge
  a_r4_zero_delay: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (trig_i && delay_i == '0) |=> pulse_o);

  // R5: a one-clock pulse with no new start drops at the next edge
  a_r5_single_width: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (start && width_i <= 1) |=> (pulse_o && wleft_q == '0));

endmodule

// File: rtl/orbit_regen.sv
module orbit_regen #(
  parameter int PER_W = 12,
  parameter int DLY_W = 12,
  parameter int WID_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_clr,
  input  logic             orb_a_in,
  input  logic             orb_b_in,
  input  logic [1:0]       src_sel,
  input  logic             auto_en,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic [WID_W-1:0] width_cfg,
  input  logic [PER_W-1:0] period_cfg,
  output logic             orb_out,
  output logic             fallback_o,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b
);

  localparam int N_EXT = 2;

  logic [N_EXT-1:0] marks;
  logic [N_EXT-1:0] rises;
  logic [CNT_W-1:0] counts [N_EXT];
  logic             local_tick;
  logic             trig;

  assign marks = {orb_b_in, orb_a_in};

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    orb_edge_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (gen_clr),
      .mark_i  (marks[i]),
      .rise_o  (rises[i]),
      .count_o (counts[i])
    );
  end

  orb_local_gen #(.PER_W(PER_W)) u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (gen_clr),
    .period_i (period_cfg),
    .tick_o   (local_tick)
  );

  orb_src_sel #(.PER_W(PER_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (gen_clr),
    .rise_a_i   (rises[0]),
    .rise_b_i   (rises[1]),
    .tick_i     (local_tick),
    .sel_i      (src_sel),
    .auto_i     (auto_en),
    .period_i   (period_cfg),
    .trig_o     (trig),
    .fallback_o (fallback_o)
  );

  orb_shaper #(.DLY_W(DLY_W), .WID_W(WID_W)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (gen_clr),
    .trig_i  (trig),
    .delay_i (delay_cfg),
    .width_i (width_cfg),
    .pulse_o (orb_out)
  );

  assign cnt_a = counts[0];
  assign cnt_b = counts[1];

  // R10: one clear cycle leaves every output at its reset value
  a_r10_general_clear: assert property (@(posedge clk) disable iff (!rst_n)
    gen_clr |=> (!orb_out && !fallback_o && cnt_a == '0 && cnt_b == '0));

endmodule

// File: tb/orbit_regen_bench.sv
module orbit_regen_bench;

  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_clr = 1'b0;
  logic        orb_a_in = 1'b0;
  logic        orb_b_in = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic        auto_en = 1'b0;
  logic [11:0] delay_cfg = '0;
  logic [7:0]  width_cfg = 8'd1;
  logic [11:0] period_cfg = 12'(P);
  logic        orb_out;
  logic        fallback_o;
  logic [31:0] cnt_a;
  logic [31:0] cnt_b;

  orbit_regen u_orbit_regen (
    .clk(clk), .rst_n(rst_n), .gen_clr(gen_clr),
    .orb_a_in(orb_a_in), .orb_b_in(orb_b_in),
    .src_sel(src_sel), .auto_en(auto_en),
    .delay_cfg(delay_cfg), .width_cfg(width_cfg), .period_cfg(period_cfg),
    .orb_out(orb_out), .fallback_o(fallback_o), .cnt_a(cnt_a), .cnt_b(cnt_b)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int    start;
    int    width;
    string req;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver side: push the pulse the requirements predict.
  task automatic expect_pulse(int start, int width, string req);
    exp_t e;
    e.start = start;
    e.width = width;
    e.req   = req;
    sbq.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic at_cycle(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drive_mark(bit beam_b, int hold);
    if (beam_b) orb_b_in = 1'b1; else orb_a_in = 1'b1;
    idle(hold);
    orb_a_in = 1'b0;
    orb_b_in = 1'b0;
  endtask

  // Monitor: measures each output pulse and compares with the queue.
  bit prev_out = 1'b0;
  int pulse_st = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (orb_out && !prev_out) pulse_st = cyc;
      if (!orb_out && prev_out) begin
        if (sbq.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R1/R2 selection: unexpected pulse at cycle %0d width %0d (expected none)",
                   pulse_st, cyc - pulse_st);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(e.req, "pulse start cycle", pulse_st, e.start);
          chk(e.req, "pulse width", cyc - pulse_st, e.width);
        end
      end
    end
    prev_out = orb_out;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1: actual hung expected finished");
    finish_run();
  end

  initial begin
    int ce;
    idle(3);
    rst_n = 1'b1;
    // reset state (R10)
    chk("R10", "orb_out after reset", orb_out, 0);
    chk("R10", "fallback after reset", fallback_o, 0);
    chk("R10", "cnt_a after reset", cnt_a, 0);
    chk("R10", "cnt_b after reset", cnt_b, 0);

    // R1: beam A, zero delay, one-clock pulse
    src_sel = 2'd0; delay_cfg = 0; width_cfg = 1;
    idle(1);
    expect_pulse(cyc + 1, 1, "R1");
    drive_mark(1'b0, 1);
    idle(5);
    chk("R7", "cnt_a after one edge", cnt_a, 1);
    // R1: beam B edge while A is selected gives no pulse
    drive_mark(1'b1, 1);
    idle(6);
    chk("R7", "cnt_b counts unselected beam", cnt_b, 1);

    // R4 / R5: delay 7, width 3
    delay_cfg = 12'd7; width_cfg = 8'd3;
    idle(1);
    expect_pulse(cyc + 1 + 7, 3, "R4");
    drive_mark(1'b0, 1);
    idle(15);

    // R5: width 0 acts as 1
    delay_cfg = 12'd2; width_cfg = 8'd0;
    idle(1);
    expect_pulse(cyc + 1 + 2, 1, "R5");
    drive_mark(1'b0, 1);
    idle(8);

    // R6: marker held four cycles
    delay_cfg = 12'd0; width_cfg = 8'd2;
    idle(1);
    expect_pulse(cyc + 1, 2, "R6");
    drive_mark(1'b0, 4);
    idle(8);
    chk("R6", "cnt_a after held marker", cnt_a, 4);

    // R2: beam B, delay 3, width 2; then A is ignored
    src_sel = 2'd1; delay_cfg = 12'd3; width_cfg = 8'd2;
    idle(1);
    expect_pulse(cyc + 1 + 3, 2, "R2");
    drive_mark(1'b1, 1);
    idle(8);
    drive_mark(1'b0, 1);
    idle(10);
    chk("R7", "cnt_b after beam B edge", cnt_b, 2);
    chk("R7", "cnt_a counts ignored edge", cnt_a, 5);

    // R3 / R10: local orbit from a cleared phase
    src_sel = 2'd2; delay_cfg = 12'd2; width_cfg = 8'd2;
    ce = cyc + 1;
    expect_pulse(ce + P + 2, 2, "R3");
    expect_pulse(ce + 2 * P + 2, 2, "R3");
    gen_clr = 1'b1;
    idle(1);
    gen_clr = 1'b0;
    chk("R10", "cnt_a after clear", cnt_a, 0);
    chk("R10", "cnt_b after clear", cnt_b, 0);
    chk("R10", "orb_out after clear", orb_out, 0);
    at_cycle(ce + 50);
    src_sel = 2'd0;
    at_cycle(ce + 70);

    // R11: silence in manual mode
    idle(3 * P);
    chk("R11", "fallback in manual silence", fallback_o, 0);

    // R8 / R9: automatic fallback and return
    auto_en = 1'b1; src_sel = 2'd0; delay_cfg = 12'd0; width_cfg = 8'd2;
    ce = cyc + 1;
    expect_pulse(ce + 5, 2, "R8");
    expect_pulse(ce + 3 * P, 2, "R8");
    expect_pulse(ce + 4 * P, 2, "R8");
    expect_pulse(ce + 90, 2, "R9");
    gen_clr = 1'b1;
    idle(1);
    gen_clr = 1'b0;
    at_cycle(ce + 4);
    drive_mark(1'b0, 1);
    at_cycle(ce + 2 * P + 4);
    chk("R8", "fallback one cycle before limit", fallback_o, 0);
    idle(1);
    chk("R8", "fallback at silence limit", fallback_o, 1);
    at_cycle(ce + 89);
    chk("R9", "fallback before return", fallback_o, 1);
    drive_mark(1'b0, 1);
    chk("R9", "fallback after returning edge", fallback_o, 0);
    at_cycle(ce + 110);
    chk("R9", "fallback stays clear with marker back", fallback_o, 0);
    auto_en = 1'b0;
    idle(10);
    chk("R1", "expected pulses left unseen", sbq.size(), 0);
    finish_run();
  end

endmodule